// File: doc/BRIEF.md
# Selectable Six-Decade Frequency Divider

The block divides one input clock by a power of ten chosen from two select inputs. Six divide-by-ten stages are chained. Each stage is a divide-by-five counter followed by a toggle flip-flop, so every stage tap is a square wave. A decoder turns the select inputs into one of six tap indices, and one register after the multiplexer drives the output. The overall ratio is 10, 100, 1,000, 10,000, 100,000 or 1,000,000.

All state moves on the falling edge of `clk_in`, and all stages share that one clock. A later stage advances only through a synchronous enable, raised when the stage below it completes a full cycle. Select-1 has three levels. Its undriven (floating) level is presented as a separate flag, `sel_lo_float`, which overrides `sel_lo`. The parameter `HALF` sets the prescaler modulus, so each stage divides by `2*HALF`. The default `HALF = 5` gives decades.

Top module: `decade_divider`

## Requirements
- R1: Stage counters and `div_out` change only at falling edges of `clk_in`, apart from reset. `div_out` holds its value across a rising edge.
- R2: While `rst` is 1, every stage and `div_out` are cleared asynchronously. `div_out` reads 0 during reset. This holds even when reset covers an edge at which the output would have risen.
- R3: Each stage divides by `2*HALF`, and tap k (k = 0..5) has a period of `(2*HALF)^(k+1)` input clocks. The default `HALF = 5` gives decades.
- R4: The select decode, written as (`sel_hi`, `sel_lo`, `sel_lo_float`) → tap index, is:
  - `float = 1` with `sel_hi = 1` → tap 5.
  - `float = 1` with `sel_hi = 0` → tap 4.
  - (0, 0, 0) → tap 3.
  - (0, 1, 0) → tap 2.
  - (1, 0, 0) → tap 1.
  - (1, 1, 0) → tap 0.
  - With `float = 1`, `sel_lo` is ignored.
- R5: `div_out` is a square wave, high for exactly N/2 input clocks and low for N/2, where N is the selected ratio.
- R6: After reset is released, `div_out` first rises at falling edge N/2+1, counting the falling edges after release. It falls N/2 edges later.
- R7: The select inputs are sampled only at falling edges. A change between edges does not alter `div_out` until the next falling edge.
- R8: A reset asserted in the middle of a count clears every stage. The next first rise after release again comes at falling edge N/2+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock; state advances on its falling edge |
| rst | input | 1 | Active-high asynchronous clear |
| sel_hi | input | 1 | Select-2 level |
| sel_lo | input | 1 | Select-1 level when driven |
| sel_lo_float | input | 1 | 1 when select-1 is left floating; overrides sel_lo |
| div_out | output | 1 | Divided square-wave output |

## Verification
Reset and an output transition can fall on the same input edge. The bench holds `rst` high across the falling edge at which the selected tap would first rise, and expects `div_out` to stay 0. It then expects the next first rise to come N/2+1 edges after release, as if no count had been under way. A select change between edges is the second collision: `div_out` must keep its old level until the next falling edge, and then show the new tap's level.

// File: rtl/decade_divider.sv
module decade_divider #(
  parameter int HALF = 5
) (
  input  logic clk_in,
  input  logic rst,
  input  logic sel_hi,
  input  logic sel_lo,
  input  logic sel_lo_float,
  output logic div_out
);
  localparam int NST = 6;
  localparam int CW  = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0]  cnt [NST];
  logic [NST-1:0] half_q;
  logic [NST-1:0] wrap;
  logic [NST-1:0] en;
  logic [2:0]     tap;

  assign en[0] = 1'b1;

  for (genvar g = 0; g < NST; g++) begin : g_stage
    assign wrap[g] = en[g] && (int'(cnt[g]) == HALF - 1);
    if (g < NST - 1) begin : g_carry
      assign en[g+1] = wrap[g] & half_q[g];
    end

    always_ff @(negedge clk_in or posedge rst) begin
      if (rst) begin
        cnt[g]    <= '0;
        half_q[g] <= 1'b0;
      end else if (wrap[g]) begin
        cnt[g]    <= '0;
        half_q[g] <= ~half_q[g];
      end else if (en[g]) begin
        cnt[g]    <= cnt[g] + 1'b1;
      end
    end

    p_digit_range_r3: assert property (@(negedge clk_in) disable iff (rst)
      int'(cnt[g]) < HALF);

    p_toggle_at_wrap_r3: assert property (@(negedge clk_in) disable iff (rst)
      (half_q[g] != $past(half_q[g])) |-> (int'($past(cnt[g])) == HALF - 1));

    if (g < NST - 1) begin : g_chk
      p_carry_r3: assert property (@(negedge clk_in) disable iff (rst)
        (cnt[g+1] != $past(cnt[g+1])) |->
          ($past(half_q[g]) && int'($past(cnt[g])) == HALF - 1));
    end
  end

  always_comb begin
    if (sel_lo_float) tap = sel_hi ? 3'd5 : 3'd4;
    else begin
      case ({sel_hi, sel_lo})
        2'b00:   tap = 3'd3;
        2'b01:   tap = 3'd2;
        2'b10:   tap = 3'd1;
        default: tap = 3'd0;
      endcase
    end
  end

  always_ff @(negedge clk_in or posedge rst) begin
    if (rst) div_out <= 1'b0;
    else     div_out <= half_q[tap];
  end

  always @(posedge clk_in) begin
    if (rst) p_reset_clear_r2: assert (div_out == 1'b0 && half_q == '0);
  end

  p_out_from_stage_r5: assert property (@(negedge clk_in) disable iff (rst)
    (div_out != $past(div_out)) |-> ($past(half_q) != '0 || $past(div_out)));
endmodule

// File: tb/decade_divider_test.sv
module decade_divider_test;
  localparam int CP = 10;
  localparam int H  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s_hi = 1'b1, s_lo = 1'b1, s_fl = 1'b0;
  logic dout;
  int checks = 0, fails = 0;

  decade_divider #(.HALF(H)) uut (
    .clk_in(clk), .rst(rst), .sel_hi(s_hi), .sel_lo(s_lo),
    .sel_lo_float(s_fl), .div_out(dout));

  always #(CP/2) clk = ~clk;

  function automatic int ratio(input int k);
    int r = 1;
    for (int i = 0; i <= k; i++) r = r * (2 * H);
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_tap(input int k);
    case (k)
      0: begin s_hi = 1; s_lo = 1; s_fl = 0; end
      1: begin s_hi = 1; s_lo = 0; s_fl = 0; end
      2: begin s_hi = 0; s_lo = 1; s_fl = 0; end
      3: begin s_hi = 0; s_lo = 0; s_fl = 0; end
      4: begin s_hi = 0; s_lo = 1; s_fl = 1; end
      default: begin s_hi = 1; s_lo = 0; s_fl = 1; end
    endcase
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst = 1;
    repeat (3) @(posedge clk);
    #1 chk("R2 reset output", int'(dout), 0);
    rst = 0;
  endtask

  task automatic wait_for(input logic v, output int n);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (dout !== v && n < 20000);
  endtask

  task automatic run_tap(input int k);
    int n, nr;
    nr = ratio(k);
    set_tap(k);
    do_reset();
    wait_for(1'b1, n); chk($sformatf("R6 R4 first rise tap%0d", k), n, nr/2 + 1);
    wait_for(1'b0, n); chk($sformatf("R5 high time tap%0d", k), n, nr/2);
    wait_for(1'b1, n); chk($sformatf("R3 low time tap%0d", k), n, nr/2);
    wait_for(1'b0, n); chk($sformatf("R5 second high tap%0d", k), n, nr/2);
  endtask

  task automatic mid_reset();
    int n, nr;
    nr = ratio(3);
    set_tap(3);
    do_reset();
    repeat (nr/2 + 23) @(posedge clk);
    @(negedge clk); #(CP/4) rst = 1;
    #1 chk("R8 async clear mid-count", int'(dout), 0);
    repeat (2) @(posedge clk);
    #1 rst = 0;
    wait_for(1'b1, n); chk("R8 rise after mid-count reset", n, nr/2 + 1);
    do_reset();
    repeat (nr/2) @(posedge clk);
    #1 rst = 1;
    @(posedge clk); #1 chk("R2 reset wins over rising edge", int'(dout), 0);
    rst = 0;
    wait_for(1'b1, n); chk("R2 rise after collision reset", n, nr/2 + 1);
  endtask

  task automatic select_hold();
    int n;
    logic v;
    set_tap(0);
    do_reset();
    wait_for(1'b1, n);
    @(negedge clk); #1 v = dout;
    @(posedge clk); #1 chk("R1 stable across rising edge", int'(dout), int'(v));
    wait_for(1'b1, n);
    set_tap(5);
    #(CP/4) chk("R7 hold until falling edge", int'(dout), 1);
    @(negedge clk); #1 chk("R7 new tap after falling edge", int'(dout), 0);
  endtask

  initial begin
    #(CP * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 6; k++) run_tap(k);
    mid_reset();
    select_hold();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule